// File: doc/BRIEF.md
# Chained Masked Vector Arithmetic Unit

This block is a small integer vector engine. It holds a bank of vector registers and runs element-wise add or multiply instructions over them. Each instruction reads two source vectors one element pair per cycle, passes them through a three-stage arithmetic pipeline and writes each result back into a destination vector. A length setting limits how many leading elements an instruction touches. An optional per-element write mask leaves chosen elements untouched.

A second instruction can start while a first one is still running, as long as it consumes the first one's destination. The second instruction then follows the first element by element. It reads each element as soon as the first instruction has committed that element, and does not wait for the whole vector. A host port loads and inspects register elements while the unit is idle.

Top module: `vchain_unit`

## Requirements
- R1: The register bank holds 8 vectors of 64 elements, each 64 bits wide. When `busy` is low, a host write (`host_we`) stores `host_wdata` into element `host_idx` of vector `host_reg`. `host_rdata` shows that element combinationally.
- R2: Opcode 0 writes `src_a[i] + src_b[i]` modulo 2^64 into `dst[i]`.
- R3: Opcode 1 writes the low 64 bits of `src_a[i] * src_b[i]` into `dst[i]`.
- R4: Call the clock edge that accepts an instruction edge k. Element i is written at edge k+3+i. `done` is high for one cycle, the cycle after edge k+vl+2. `busy` is high from edge k until edge k+vl+3.
- R5: Elements at index vl and above are left unchanged. The length is the value written through `vlen_we`, where any value above 64 counts as 64. Each instruction keeps the length that was in force when it was accepted.
- R6: When `iss_mask_en` is 1, element i is written only if bit i of the mask register is 1. Bit 0 belongs to element 0.
- R7: When `iss_mask_en` is 0, every element below vl is written, whatever the mask register holds.
- R8: With vl = 0, `done` is high in the cycle right after the issue edge and `busy` falls at the next edge. No element is written.
- R9: A second instruction is accepted while one runs only if all three of these hold: no chained instruction is already running; its source A or source B equals the running destination; its destination differs from the running destination and from both running sources. It then reads element j one cycle after the first instruction writes element j. The results match sequential execution. If it is issued one cycle after the first instruction, `busy` falls vl+6 edges after the first issue edge.
- R10: Any other issue attempt while busy sees `iss_ready` low and is not accepted.
- R11: A host write while `busy` is high has no effect.
- R12: After reset, `busy` and `done` are low and `iss_ready` is high. The length is 64 and the mask register is all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Instruction offered |
| iss_op | input | 1 | 0 add, 1 multiply |
| iss_sa | input | 3 | Source A vector |
| iss_sb | input | 3 | Source B vector |
| iss_dst | input | 3 | Destination vector |
| iss_mask_en | input | 1 | Apply mask register |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| vlen_we | input | 1 | Write length setting |
| vlen_in | input | 7 | New length (clamped to 64) |
| mask_we | input | 1 | Write mask register |
| mask_in | input | 64 | New mask, bit i for element i |
| busy | output | 1 | An instruction is in flight |
| done | output | 1 | An instruction finished this cycle |
| host_we | input | 1 | Host element write |
| host_reg | input | 3 | Host vector select |
| host_idx | input | 6 | Host element select |
| host_wdata | input | 64 | Host write data |
| host_rdata | output | 64 | Selected element |

## Verification
A wrong element counter or a bad mask capture shows up as a corrupted or untouched element in the destination vector. The bench reads every element back through the host port right after `done`, so such faults appear at the first readback. A chaining gate that opens too early produces stale operands in the chained result. A gate that opens too late stretches the measured `busy` window, so it appears as a cycle-count mismatch on the first chained pair. Issue-gating errors show up in the same cycle, because `iss_ready` is sampled before each conflicting offer.

// File: rtl/vchain_unit.sv
module vchain_unit #(
  parameter int NREG  = 8,
  parameter int NELEM = 64,
  parameter int W     = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       iss_valid,
  input  logic                       iss_op,
  input  logic [$clog2(NREG)-1:0]    iss_sa,
  input  logic [$clog2(NREG)-1:0]    iss_sb,
  input  logic [$clog2(NREG)-1:0]    iss_dst,
  input  logic                       iss_mask_en,
  output logic                       iss_ready,
  input  logic                       vlen_we,
  input  logic [$clog2(NELEM+1)-1:0] vlen_in,
  input  logic                       mask_we,
  input  logic [NELEM-1:0]           mask_in,
  output logic                       busy,
  output logic                       done,
  input  logic                       host_we,
  input  logic [$clog2(NREG)-1:0]    host_reg,
  input  logic [$clog2(NELEM)-1:0]   host_idx,
  input  logic [W-1:0]               host_wdata,
  output logic [W-1:0]               host_rdata
);
  localparam int RW = $clog2(NREG);
  localparam int EW = $clog2(NELEM);
  localparam int LW = $clog2(NELEM+1);

  logic [W-1:0]     rf [NREG][NELEM];
  logic [LW-1:0]    vlen;
  logic [NELEM-1:0] mreg;

  logic [1:0]       act, op, p1v, p2v, p1we, p2we, rd, fin;
  logic [LW-1:0]    cnt [2];
  logic [LW-1:0]    vl [2];
  logic [LW-1:0]    wcnt0;
  logic [NELEM-1:0] msk [2];
  logic [RW-1:0]    sa [2];
  logic [RW-1:0]    sb [2];
  logic [RW-1:0]    dd [2];
  logic [W-1:0]     p1a [2];
  logic [W-1:0]     p1b [2];
  logic [W-1:0]     p2r [2];
  logic [EW-1:0]    p1i [2];
  logic [EW-1:0]    p2i [2];

  always_comb begin
    for (int s = 0; s < 2; s++) begin
      rd[s]  = act[s] && (cnt[s] < vl[s]) && (s == 0 || !act[0] || cnt[s] < wcnt0);
      fin[s] = act[s] && (cnt[s] == vl[s]) && !p1v[s] && !p2v[s];
    end
  end

  wire chainable = (iss_sa == dd[0] || iss_sb == dd[0]) &&
                   iss_dst != dd[0] && iss_dst != sa[0] && iss_dst != sb[0];
  assign iss_ready  = !act[1] && (!act[0] || chainable);
  wire take         = iss_valid && iss_ready;
  wire tgt          = act[0];
  assign busy       = |act;
  assign done       = |fin;
  assign host_rdata = rf[host_reg][host_idx];
  wire [LW-1:0] vclamp = (vlen_in > LW'(NELEM)) ? LW'(NELEM) : vlen_in;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act   <= '0;
      p1v   <= '0;
      p2v   <= '0;
      vlen  <= LW'(NELEM);
      mreg  <= '1;
      wcnt0 <= '0;
    end else begin
      if (vlen_we) vlen <= vclamp;
      if (mask_we) mreg <= mask_in;
      for (int s = 0; s < 2; s++) begin
        p2v[s]  <= p1v[s];
        p2we[s] <= p1we[s];
        p2i[s]  <= p1i[s];
        p2r[s]  <= op[s] ? p1a[s] * p1b[s] : p1a[s] + p1b[s];
        p1v[s]  <= rd[s];
        if (rd[s]) begin
          p1a[s]  <= rf[sa[s]][cnt[s][EW-1:0]];
          p1b[s]  <= rf[sb[s]][cnt[s][EW-1:0]];
          p1i[s]  <= cnt[s][EW-1:0];
          p1we[s] <= msk[s][cnt[s][EW-1:0]];
          cnt[s]  <= cnt[s] + LW'(1);
        end
        if (fin[s]) act[s] <= 1'b0;
      end
      if (take && !act[0]) wcnt0 <= '0;
      else if (p2v[0])     wcnt0 <= wcnt0 + LW'(1);
      if (take) begin
        act[tgt] <= 1'b1;
        cnt[tgt] <= '0;
        vl[tgt]  <= vlen;
        msk[tgt] <= iss_mask_en ? mreg : '1;
        op[tgt]  <= iss_op;
        sa[tgt]  <= iss_sa;
        sb[tgt]  <= iss_sb;
        dd[tgt]  <= iss_dst;
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < 2; s++)
      if (p2v[s] && p2we[s]) rf[dd[s]][p2i[s]] <= p2r[s];
    if (host_we && !busy) rf[host_reg][host_idx] <= host_wdata;
  end
endmodule

// File: rtl/vchain_unit_chk.sv
module vchain_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       iss_valid,
  input logic       iss_ready,
  input logic [1:0] wr_act
);
  a_r12_idle_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> iss_ready);
  a_r4_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);
  a_r4_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && iss_ready) |=> busy);
  a_r4_fall_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(done));
  a_r11_writes_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_act) |-> busy);
endmodule

bind vchain_unit vchain_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done),
  .iss_valid(iss_valid), .iss_ready(iss_ready), .wr_act(p2v)
);

// File: tb/test_vchain_unit.sv
`timescale 1ns/1ps
module test_vchain_unit;
  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_op = 0, iss_mask_en = 0;
  logic [2:0] iss_sa = 0, iss_sb = 0, iss_dst = 0;
  logic iss_ready, busy, done;
  logic vlen_we = 0, mask_we = 0, host_we = 0;
  logic [6:0] vlen_in = 0;
  logic [63:0] mask_in = 0, host_wdata = 0, host_rdata;
  logic [2:0] host_reg = 0;
  logic [5:0] host_idx = 0;

  int checks = 0, errors = 0;
  logic [63:0] m [8][64];
  logic [63:0] bmask = '1;
  int bvl = 64;

  always #2 clk = ~clk;

  vchain_unit i_vchain_unit (.*);

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic hwrite(input int r, input int i, input logic [63:0] d);
    @(negedge clk);
    host_we = 1; host_reg = 3'(r); host_idx = 6'(i); host_wdata = d;
    @(negedge clk);
    host_we = 0;
  endtask

  task automatic check_reg(input int r, input string req);
    int bad = -1;
    logic [63:0] got = 0;
    host_reg = 3'(r);
    for (int i = 0; i < 64; i++) begin
      host_idx = 6'(i);
      #0.1;
      if (bad < 0 && host_rdata !== m[r][i]) begin bad = i; got = host_rdata; end
    end
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s v%0d[%0d] actual %h expected %h", req, r, bad, got, m[r][bad]);
    end
  endtask

  task automatic set_vlen(input int v);
    @(negedge clk);
    vlen_we = 1; vlen_in = 7'(v);
    @(negedge clk);
    vlen_we = 0;
    bvl = (v > 64) ? 64 : v;
  endtask

  task automatic set_mask(input logic [63:0] mk);
    @(negedge clk);
    mask_we = 1; mask_in = mk;
    @(negedge clk);
    mask_we = 0;
    bmask = mk;
  endtask

  task automatic model(input bit o, input int a, input int b, input int d, input bit men);
    for (int i = 0; i < bvl; i++)
      if (!men || bmask[i]) m[d][i] = o ? m[a][i] * m[b][i] : m[a][i] + m[b][i];
  endtask

  task automatic drive(input bit o, input int a, input int b, input int d, input bit men);
    iss_valid = 1; iss_op = o; iss_sa = 3'(a); iss_sb = 3'(b);
    iss_dst = 3'(d); iss_mask_en = men;
  endtask

  task automatic run(input bit o, input int a, input int b, input int d, input bit men,
                     output int cdone, output int cbusy);
    int c = 0;
    @(negedge clk);
    drive(o, a, b, d, men);
    @(negedge clk);
    iss_valid = 0;
    cdone = -1;
    while (busy) begin
      if (done && cdone < 0) cdone = c;
      @(negedge clk);
      c++;
    end
    if (done && cdone < 0) cdone = c;
    cbusy = c;
    model(o, a, b, d, men);
  endtask

  task automatic t_reset;
    chk(busy == 0, "R12 busy", longint'(busy), 0);
    chk(done == 0, "R12 done", longint'(done), 0);
    chk(iss_ready == 1, "R12 ready", longint'(iss_ready), 1);
  endtask

  task automatic t_load;
    for (int r = 0; r < 8; r++)
      for (int i = 0; i < 64; i++) begin
        m[r][i] = (r == 1) ? (64'hFFFF_FFFF_FFFF_FFF0 + 64'(i)) :
                  {32'(r * 977 + i * 13), 32'(i * 40503 + r)};
        hwrite(r, i, m[r][i]);
      end
    check_reg(0, "R1 load v0");
    check_reg(1, "R1 load v1");
  endtask

  task automatic t_add;
    int cd, cb;
    run(0, 0, 1, 2, 1, cd, cb);
    check_reg(2, "R2 R12 add wraps, default mask and length");
    chk(cd == 66, "R4 done cycle", cd, 66);
    chk(cb == 67, "R4 busy end", cb, 67);
  endtask

  task automatic t_mul;
    int cd, cb;
    run(1, 0, 1, 3, 0, cd, cb);
    check_reg(3, "R3 multiply low bits");
  endtask

  task automatic t_vlen;
    int cd, cb;
    set_vlen(10);
    run(0, 0, 2, 4, 0, cd, cb);
    check_reg(4, "R5 length 10 leaves tail");
    chk(cd == 12, "R4 R5 done cycle at length 10", cd, 12);
    set_vlen(100);
    run(1, 1, 1, 5, 0, cd, cb);
    check_reg(5, "R5 length clamp to 64");
  endtask

  task automatic t_mask;
    int cd, cb;
    set_mask(64'hA5A5_0F0F_3333_8001);
    run(0, 0, 1, 6, 1, cd, cb);
    check_reg(6, "R6 masked writes");
    run(1, 2, 3, 6, 0, cd, cb);
    check_reg(6, "R7 mask disabled writes all");
  endtask

  task automatic t_vl0;
    int cd, cb;
    set_vlen(0);
    run(0, 0, 0, 7, 0, cd, cb);
    check_reg(7, "R8 no writes at length 0");
    chk(cd == 0, "R8 done cycle", cd, 0);
    chk(cb == 1, "R8 busy end", cb, 1);
    set_vlen(64);
  endtask

  task automatic t_host_busy;
    int c = 0;
    @(negedge clk);
    drive(0, 0, 1, 2, 0);
    @(negedge clk);
    iss_valid = 0;
    host_we = 1; host_reg = 3'd7; host_idx = 6'd3; host_wdata = 64'hDEAD_BEEF;
    @(negedge clk);
    host_we = 0;
    while (busy && c < 200) begin @(negedge clk); c++; end
    model(0, 0, 1, 2, 0);
    check_reg(7, "R11 host write ignored while busy");
    check_reg(2, "R11 op result unaffected");
  endtask

  task automatic t_conflict;
    int c = 0;
    @(negedge clk);
    drive(1, 3, 4, 5, 0);
    @(negedge clk);
    iss_valid = 0;
    iss_sa = 3'd0; iss_sb = 3'd1; iss_dst = 3'd6;
    #0.1;
    chk(iss_ready == 0, "R10 independent op stalled", longint'(iss_ready), 0);
    iss_sa = 3'd5; iss_dst = 3'd5;
    #0.1;
    chk(iss_ready == 0, "R10 same destination stalled", longint'(iss_ready), 0);
    iss_dst = 3'd3;
    #0.1;
    chk(iss_ready == 0, "R10 destination over running source stalled", longint'(iss_ready), 0);
    while (busy && c < 200) begin @(negedge clk); c++; end
    model(1, 3, 4, 5, 0);
    check_reg(5, "R10 first op result");
    chk(iss_ready == 1, "R10 ready after done", longint'(iss_ready), 1);
  endtask

  task automatic t_chain;
    int c = 1;
    bit rdy;
    @(negedge clk);
    drive(0, 0, 1, 4, 0);
    @(negedge clk);
    drive(1, 3, 4, 5, 1);
    #0.1;
    rdy = iss_ready;
    @(negedge clk);
    iss_valid = 0;
    while (busy && c < 300) begin @(negedge clk); c++; end
    chk(rdy == 1, "R9 chained issue accepted", longint'(rdy), 1);
    chk(c == 70, "R9 chained pair busy span", c, 70);
    model(0, 0, 1, 4, 0);
    model(1, 3, 4, 5, 1);
    check_reg(4, "R9 first of chain");
    check_reg(5, "R9 chained result");
  endtask

  initial begin
    #(4 * 150000);
    errors++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_load();
    t_add();
    t_mul();
    t_vlen();
    t_mask();
    t_vl0();
    t_host_busy();
    t_conflict();
    t_chain();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule